// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Non-Maskable Override

This block collects a parameterised set of maskable interrupt request lines and one non-maskable request, and reduces them to a single winner every clock. Software gives each maskable source a 5-bit priority level through a small write port. The block presents the winner's level and interrupt number to the processor, together with a valid flag. It also presents the winner's byte offset into the vector table and the full vector address formed from a table base.

The non-maskable request beats every maskable source and reports a fixed level/number pair. It also raises a sticky hold-off flag that drives a DMA-inhibit output. Only a software write of zero to that flag removes it, and the interrupt service routine does this when it finishes. Level masking in the processor, the vector fetch and the DMA engine itself belong to neighbouring blocks.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, valid is 0, the level output is 31, the number output is 0, dma_inhibit is 0, and every source level register holds 31.
- R2: A write with wr_addr equal to k (0 to NUM_SRC-1) loads wr_data into the level register of source k. The new level governs arbitration from the cycle after the write.
- R3: A pending source whose level register holds 31 (binary 11111) is never selected.
- R4: Among pending enabled sources, the one with the numerically smallest level wins and its level is reported.
- R5: Source k reports interrupt number BASE_NUM+k. When levels tie, the lower number wins.
- R6: When nmi_req is 1, it wins over all maskable requests and reports level 15 (5'b01111) and number 15 (7'b0001111).
- R7: vec_off equals 0x3FC minus 4 times the reported number, and vec_addr equals TBL_BASE plus vec_off.
- R8: The level, number, valid, offset and address outputs are registered and change at the first clock edge after the inputs change. With nothing pending, valid is 0, the level is 31 and the number is 0.
- R9: A cycle with nmi_req at 1 sets the halt flag. dma_inhibit reads 1 from the next clock and stays 1 after nmi_req falls.
- R10: A write with wr_addr equal to NUM_SRC and wr_data[0]=0 clears the halt flag. If nmi_req is 1 in the same cycle, the flag stays set.
- R11: A write of 1 (wr_data[0]=1) to address NUM_SRC leaves the halt flag unchanged, so it cannot set dma_inhibit.
- R12: The hardware never reports a number of 80 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Maskable request lines, bit k is source k |
| nmi_req | input | 1 | Non-maskable request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | 0..NUM_SRC-1 level registers, NUM_SRC halt flag |
| wr_data | input | 5 | Write data (bit 0 only for the halt flag) |
| int_valid | output | 1 | An interrupt is being reported |
| int_level | output | 5 | Reported interrupt level |
| int_num | output | 7 | Reported interrupt number |
| vec_off | output | 10 | Vector table byte offset |
| vec_addr | output | 32 | TBL_BASE plus vec_off |
| dma_inhibit | output | 1 | DMA hold-off, mirrors the halt flag |

## Verification
A request change is visible on the level, number, valid and offset outputs one clock edge later. A level write takes two edges: one to load the register and one for the output register. The halt flag reacts to a set or clear one edge after the cycle that carried it. The bench changes inputs on the falling edge and checks on the next falling edge, so exactly one rising edge lies between stimulus and check. A separate check samples before that edge to confirm that the outputs have not yet moved.

// File: rtl/prio_irq_pkg.sv
// Package: shared encodings for the priority interrupt arbiter.
// Assumes the level field is 5 bits and the number field is 7 bits.
package prio_irq_pkg;
    localparam int LVL_W = 5;
    localparam int NUM_W = 7;
    localparam int OFF_W = 10;

    localparam logic [LVL_W-1:0] LVL_OFF = 5'd31;
    localparam logic [LVL_W-1:0] NMI_LVL = 5'd15;
    localparam logic [NUM_W-1:0] NMI_NUM = 7'd15;
    localparam logic [OFF_W-1:0] OFF_TOP = 10'h3FC;

    // Vector table offset for an interrupt number: top slot minus four bytes per number.
    function automatic logic [OFF_W-1:0] vec_offset(input logic [NUM_W-1:0] num);
        return OFF_TOP - {1'b0, num, 2'b00};
    endfunction
endpackage

// File: rtl/pic_level_bank.sv
// Module: one 5-bit priority register per maskable source.
// Assumes wr_addr values at or above NUM_SRC address something else (ignored here).
// Reset value is the disable code, so no source competes until programmed.
module pic_level_bank
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [LVL_W-1:0]               wr_data,
    output logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
        // Load this source's level when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_o[g] <= LVL_OFF;
            else if (wr_en && wr_addr == ADDR_W'(g))
                lvl_o[g] <= wr_data;
        end
    end
endmodule

// File: rtl/pic_arbiter.sv
// Module: combinational winner search over the maskable sources.
// Smallest level wins; a tie goes to the lower index; level 31 never competes.
// Assumes NUM_SRC >= 2 and BASE_NUM + NUM_SRC <= 80.
module pic_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int BASE_NUM = 72
) (
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_i,
    output logic                           hit_o,
    output logic [LVL_W-1:0]               lvl_o,
    output logic [NUM_W-1:0]               num_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] elig;
    logic [IDX_W-1:0]   best_idx;
    logic [LVL_W-1:0]   best_lvl;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        assign elig[g] = req_i[g] && (lvl_i[g] != LVL_OFF);
    end

    // Scan upward; strict less-than keeps the lower index on a tie.
    always_comb begin
        best_lvl = LVL_OFF;
        best_idx = '0;
        hit_o    = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!hit_o || lvl_i[i] < best_lvl)) begin
                best_lvl = lvl_i[i];
                best_idx = IDX_W'(i);
                hit_o    = 1'b1;
            end
        end
    end

    assign lvl_o = best_lvl;
    assign num_o = NUM_W'(BASE_NUM) + NUM_W'(best_idx);
endmodule

// File: rtl/pic_halt_flag.sv
// Module: sticky DMA hold-off flag.
// Set by the non-maskable request; cleared only by an explicit clear strobe.
// Set wins over clear in the same cycle.
module pic_halt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic halt_o
);
    // Hold the flag until software clears it and no new set is present.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_o <= 1'b0;
        else if (set_i)
            halt_o <= 1'b1;
        else if (clr_i)
            halt_o <= 1'b0;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the priority interrupt arbiter with non-maskable override.
// Registers the winner's level, number, vector offset and address one clock
// after the requests. Writes to address NUM_SRC reach the halt flag; only a
// zero in bit 0 has an effect there.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int          NUM_SRC  = 8,
    parameter int          BASE_NUM = 72,
    parameter logic [31:0] TBL_BASE = 32'h0001_0000,
    parameter int          ADDR_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               nmi_req,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [4:0]         wr_data,
    output logic               int_valid,
    output logic [4:0]         int_level,
    output logic [6:0]         int_num,
    output logic [9:0]         vec_off,
    output logic [31:0]        vec_addr,
    output logic               dma_inhibit
);
    localparam logic [ADDR_W-1:0] HALT_ADDR = ADDR_W'(NUM_SRC);

    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
    logic                          arb_hit;
    logic [LVL_W-1:0]              arb_lvl;
    logic [NUM_W-1:0]              arb_num;
    logic                          halt_clr;
    logic                          nxt_valid;
    logic [LVL_W-1:0]              nxt_lvl;
    logic [NUM_W-1:0]              nxt_num;

    pic_level_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lvl_o   (src_lvl)
    );

    pic_arbiter #(.NUM_SRC(NUM_SRC), .BASE_NUM(BASE_NUM)) u_arb (
        .req_i (irq_req),
        .lvl_i (src_lvl),
        .hit_o (arb_hit),
        .lvl_o (arb_lvl),
        .num_o (arb_num)
    );

    assign halt_clr = wr_en && (wr_addr == HALT_ADDR) && !wr_data[0];

    pic_halt_flag u_halt (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (nmi_req),
        .clr_i  (halt_clr),
        .halt_o (dma_inhibit)
    );

    // Choose the non-maskable code first, then the arbiter winner, else idle.
    always_comb begin
        if (nmi_req) begin
            nxt_valid = 1'b1;
            nxt_lvl   = NMI_LVL;
            nxt_num   = NMI_NUM;
        end else if (arb_hit) begin
            nxt_valid = 1'b1;
            nxt_lvl   = arb_lvl;
            nxt_num   = arb_num;
        end else begin
            nxt_valid = 1'b0;
            nxt_lvl   = LVL_OFF;
            nxt_num   = '0;
        end
    end

    // Register the report and its vector location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_valid <= 1'b0;
            int_level <= LVL_OFF;
            int_num   <= '0;
            vec_off   <= OFF_TOP;
            vec_addr  <= TBL_BASE + {22'd0, OFF_TOP};
        end else begin
            int_valid <= nxt_valid;
            int_level <= nxt_lvl;
            int_num   <= nxt_num;
            vec_off   <= vec_offset(nxt_num);
            vec_addr  <= TBL_BASE + {22'd0, vec_offset(nxt_num)};
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Module: protocol checker for prio_irq_ctrl, bound to every instance.
module prio_irq_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               nmi_req,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               wr_bit0,
    input logic               int_valid,
    input logic [4:0]         int_level,
    input logic [6:0]         int_num,
    input logic               dma_inhibit
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == ADDR_W'(NUM_SRC)) && !wr_bit0;

    // R6
    nmi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> (int_valid && int_level == 5'd15 && int_num == 7'd15));
    // R9
    nmi_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> dma_inhibit);
    // R10
    halt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_inhibit && !clr_wr) |=> dma_inhibit);
    // R11
    halt_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_inhibit && !nmi_req) |=> !dma_inhibit);
    // R8
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_valid |-> (int_level == 5'd31 && int_num == 7'd0));
    // R8
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req == '0 && !nmi_req) |=> !int_valid);
    // R12
    num_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> int_num < 7'd80);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .nmi_req     (nmi_req),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_bit0     (wr_data[0]),
    .int_valid   (int_valid),
    .int_level   (int_level),
    .int_num     (int_num),
    .dma_inhibit (dma_inhibit)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int          NSRC  = 8;
    localparam int          BASEN = 72;
    localparam logic [31:0] TBASE = 32'h0001_0000;
    localparam int          AW    = 4;
    localparam int          NVEC  = 10;

    // {req[7:0], nmi, exp_valid, exp_level[4:0], exp_num[6:0]}
    localparam logic [21:0] VEC [NVEC] = '{
        {8'h00, 1'b0, 1'b0, 5'd31,  7'd0},
        {8'h01, 1'b0, 1'b1, 5'd10, 7'd72},
        {8'h03, 1'b0, 1'b1, 5'd3,  7'd73},
        {8'h06, 1'b0, 1'b1, 5'd3,  7'd73},
        {8'h84, 1'b0, 1'b1, 5'd3,  7'd74},
        {8'h10, 1'b0, 1'b0, 5'd31,  7'd0},
        {8'hFF, 1'b0, 1'b1, 5'd0,  7'd77},
        {8'h48, 1'b0, 1'b1, 5'd7,  7'd78},
        {8'h80, 1'b0, 1'b1, 5'd3,  7'd79},
        {8'h20, 1'b1, 1'b1, 5'd15, 7'd15}
    };
    // Programmed levels, source 0 first (source 4 stays disabled).
    localparam logic [4:0] LV [NSRC] = '{5'd10, 5'd3, 5'd3, 5'd20, 5'd31, 5'd0, 5'd7, 5'd3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] irq_req = '0;
    logic nmi_req = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [4:0] wr_data = '0;
    logic int_valid, dma_inhibit;
    logic [4:0] int_level;
    logic [6:0] int_num;
    logic [9:0] vec_off;
    logic [31:0] vec_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(NSRC), .BASE_NUM(BASEN), .TBL_BASE(TBASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .int_valid(int_valid), .int_level(int_level), .int_num(int_num),
        .vec_off(vec_off), .vec_addr(vec_addr), .dma_inhibit(dma_inhibit)
    );

    task automatic chk_out(input string tag, input logic v, input logic [4:0] l, input logic [6:0] n);
        logic [9:0] eo;
        eo = 10'h3FC - {1'b0, n, 2'b00};
        n_chk++;
        if (int_valid !== v || int_level !== l || int_num !== n ||
            vec_off !== eo || vec_addr !== TBASE + {22'd0, eo}) begin
            n_bad++;
            $display("FAIL %s: got v=%0d lvl=%0d num=%0d off=%h addr=%h, expected v=%0d lvl=%0d num=%0d off=%h addr=%h",
                     tag, int_valid, int_level, int_num, vec_off, vec_addr,
                     v, l, n, eo, TBASE + {22'd0, eo});
        end
    endtask

    task automatic chk_dma(input string tag, input logic e);
        n_chk++;
        if (dma_inhibit !== e) begin
            n_bad++;
            $display("FAIL %s: dma_inhibit got %0d expected %0d", tag, dma_inhibit, e);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic apply(input logic [NSRC-1:0] r, input logic nm);
        @(negedge clk);
        irq_req = r; nmi_req = nm;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 reset outputs", 1'b0, 5'd31, 7'd0);
        chk_dma("R1 reset halt flag", 1'b0);
        apply(8'hFF, 1'b0);
        chk_out("R1 R3 all levels disabled after reset", 1'b0, 5'd31, 7'd0);
        apply(8'h00, 1'b0);

        // R11: writing 1 to the halt flag does not set it
        wr(AW'(NSRC), 5'd1);
        @(negedge clk);
        chk_dma("R11 write of one ignored", 1'b0);

        // R2: program levels
        for (int k = 0; k < NSRC; k++) wr(AW'(k), LV[k]);

        // Table walk: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][21:14], VEC[i][13]);
            chk_out($sformatf("R3 R4 R5 R6 R7 R8 vector %0d", i),
                    VEC[i][12], VEC[i][11:7], VEC[i][6:0]);
        end
        chk_dma("R9 set by nmi", 1'b1);

        // R9: flag persists after nmi drops
        apply(8'h00, 1'b0);
        chk_out("R8 idle after nmi drop", 1'b0, 5'd31, 7'd0);
        chk_dma("R9 sticky after nmi drop", 1'b1);
        wr(AW'(NSRC), 5'd1);
        chk_dma("R11 write of one leaves flag set", 1'b1);

        // R10: software clear
        wr(AW'(NSRC), 5'd0);
        chk_dma("R10 cleared by zero write", 1'b0);

        // R10: nmi wins over a clear in the same cycle
        @(negedge clk);
        nmi_req = 1'b1; wr_en = 1'b1; wr_addr = AW'(NSRC); wr_data = 5'd0;
        @(negedge clk);
        nmi_req = 1'b0; wr_en = 1'b0;
        chk_dma("R10 nmi beats clear", 1'b1);
        wr(AW'(NSRC), 5'd0);
        chk_dma("R10 clear after collision", 1'b0);

        // R8: latency, outputs unchanged before the edge
        @(negedge clk);
        irq_req = 8'h01;
        #5;
        chk_out("R8 no change before edge", 1'b0, 5'd31, 7'd0);
        @(negedge clk);
        chk_out("R8 change after one edge", 1'b1, 5'd10, 7'd72);

        // R2: reprogram levels at run time
        wr(AW'(5), 5'd31);
        apply(8'h20, 1'b0);
        chk_out("R2 R3 source 5 disabled by write", 1'b0, 5'd31, 7'd0);
        wr(AW'(0), 5'd2);
        apply(8'h03, 1'b0);
        chk_out("R2 R4 source 0 raised above source 1", 1'b1, 5'd2, 7'd72);
        wr(AW'(6), 5'd2);
        apply(8'h41, 1'b0);
        chk_out("R5 tie goes to lower number", 1'b1, 5'd2, 7'd72);
        apply(8'h40, 1'b0);
        chk_out("R7 R12 source 6 vector", 1'b1, 5'd2, 7'd78);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule